// File: doc/BRIEF.md
# Banked Memory-Attribute Register Access Gate

This block owns one 32-bit memory-attribute system register kept as two banks, a Secure copy and a Non-secure copy. It watches coprocessor move-to (write) and move-from (read) requests. It accepts only the single encoding that names this register and ignores every other encoding. For each accepted request it decides whether the access completes, traps to the hypervisor level with a syndrome code, or is undefined. The decision uses the requester's exception level, the hypervisor enable, three trap-control bits, the secure-state bit and two secure-lockout lines. A completed read returns the chosen bank. A completed write updates it.

The request and all of its control inputs are captured in the cycle the request is accepted. A two-state machine produces the response one cycle later. In state `ST_IDLE` no response is driven. An accepted request moves it to `ST_RESP`, where the verdict, syndrome and read data are driven for exactly one cycle. From `ST_RESP` it stays in `ST_RESP` if another accepted request arrives in that same cycle (back-to-back), and otherwise it returns to `ST_IDLE`. A completed write commits at the clock edge that ends the `ST_RESP` cycle, so a read accepted in that same cycle already sees the new value.

The register has two named views, short-descriptor and long-descriptor, but both views map onto the same 32 bits of each bank. The block therefore needs no view input. The Non-secure bank also serves as the single shared copy on systems that have no 32-bit secure monitor level. The block does not decode the attribute fields.

Top module: `attr_reg_gate`

## Requirements
- R1: A request is accepted only when `req_valid` is high and the encoding is coprocessor 15, opc1 0, CRn 10, CRm 2, opc2 1. Any other encoding produces no response and changes no bank.
- R2: When `feat_present` is low, every accepted access is undefined, whatever the other inputs are.
- R3: Any accepted access with `cur_level` = 0 (EL0) is undefined. Levels are encoded 0 = EL0, 1 = EL1, 2 = EL2, 3 = EL3.
- R4: At EL1 with `hyp_enable` high, `trap_crn10` high traps the access (read or write) with syndrome 0x03. This check comes before the virtual-memory trap check.
- R5: At EL1 with `hyp_enable` high and `trap_crn10` low, a read traps if `trap_vm_read` is high and a write traps if `trap_vm_write` is high, each with syndrome 0x03. The other direction's bit has no effect. With `hyp_enable` low, no trap bit has any effect.
- R6: Completed EL1 and EL2 accesses use the Non-secure bank. Trap bits have no effect at EL2.
- R7: At EL3, `nonsecure` = 0 selects the Secure bank and `nonsecure` = 1 selects the Non-secure bank.
- R8: At EL3 with `nonsecure` = 0, a write is undefined if `sec_lock_a` or `sec_lock_b` is high. Reads and Non-secure writes are not blocked by these lines.
- R10: The response is a one-cycle `rsp_valid` pulse in the cycle after acceptance. `rsp_outcome` is 0 for done, 1 for trap and 2 for undefined. `rsp_syndrome` is 0x03 on a trap and 0 otherwise. `rsp_rdata` is the bank value on a completed read and 0 otherwise. Requests accepted back to back get responses in consecutive cycles.
- R11: Both banks reset to zero. A write that traps or is undefined leaves both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_coproc | input | 4 | Coprocessor number |
| req_opc1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_opc2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| feat_present | input | 1 | The 32-bit EL1 feature is implemented |
| cur_level | input | 2 | Requester exception level |
| hyp_enable | input | 1 | Hypervisor level is enabled |
| trap_crn10 | input | 1 | Per-register-group trap bit |
| trap_vm_read | input | 1 | Virtual-memory read trap bit |
| trap_vm_write | input | 1 | Virtual-memory write trap bit |
| nonsecure | input | 1 | Secure-state bit used at EL3 |
| sec_lock_a | input | 1 | First secure write-lockout line |
| sec_lock_b | input | 1 | Second secure write-lockout line |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_outcome | output | 2 | 0 done, 1 trap, 2 undefined |
| rsp_syndrome | output | 8 | Trap syndrome, 0 unless trapped |
| rsp_rdata | output | 32 | Read data on a completed read |

## Verification
The assertions assume that every control input is meaningful only in the cycle in which `req_valid` is high. They also assume the control inputs are settled at the sampling edge, and that `cur_level` always holds one of the four legal codes. The bench drives every request and its full context together at the falling edge and holds them for exactly one cycle. The only exception is the back-to-back case, where a second complete request follows in the next cycle. No control input ever changes in the middle of a cycle.

// File: rtl/attr_reg_pkg.sv
package attr_reg_pkg;
    typedef enum logic [1:0] {
        OUT_DONE  = 2'd0,
        OUT_TRAP  = 2'd1,
        OUT_UNDEF = 2'd2
    } outcome_e;

    typedef enum logic [1:0] {
        LVL_EL0 = 2'd0,
        LVL_EL1 = 2'd1,
        LVL_EL2 = 2'd2,
        LVL_EL3 = 2'd3
    } level_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    localparam int NUM_BANKS  = 2;
    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam logic [BANK_SEL_W-1:0] BANK_SEC  = BANK_SEL_W'(0);
    localparam logic [BANK_SEL_W-1:0] BANK_NSEC = BANK_SEL_W'(1);

    typedef struct packed {
        logic   write;
        level_e lvl;
        logic   feat;
        logic   hyp_en;
        logic   trap_grp;
        logic   trap_vm_rd;
        logic   trap_vm_wr;
        logic   nonsec;
        logic   lock_a;
        logic   lock_b;
    } ctx_t;
endpackage

// File: rtl/attr_enc_match.sv
module attr_enc_match #(
    parameter logic [3:0] MATCH_CP   = 4'd15,
    parameter logic [2:0] MATCH_OPC1 = 3'd0,
    parameter logic [3:0] MATCH_CRN  = 4'd10,
    parameter logic [3:0] MATCH_CRM  = 4'd2,
    parameter logic [2:0] MATCH_OPC2 = 3'd1
) (
    input  logic [3:0] coproc,
    input  logic [2:0] opc1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] opc2,
    output logic       hit
);
    assign hit = (coproc == MATCH_CP) && (opc1 == MATCH_OPC1) &&
                 (crn == MATCH_CRN) && (crm == MATCH_CRM) && (opc2 == MATCH_OPC2);
endmodule

// File: rtl/attr_access_judge.sv
module attr_access_judge
    import attr_reg_pkg::*;
(
    input  ctx_t                  ctx,
    output outcome_e              verdict,
    output logic [BANK_SEL_W-1:0] bank_sel
);
    always_comb begin
        verdict  = OUT_DONE;
        bank_sel = BANK_NSEC;
        if (!ctx.feat) begin
            verdict = OUT_UNDEF;
        end else begin
            unique case (ctx.lvl)
                LVL_EL0: verdict = OUT_UNDEF;
                LVL_EL1: begin
                    if (ctx.hyp_en && ctx.trap_grp)
                        verdict = OUT_TRAP;
                    else if (ctx.hyp_en && (ctx.write ? ctx.trap_vm_wr : ctx.trap_vm_rd))
                        verdict = OUT_TRAP;
                end
                LVL_EL2: verdict = OUT_DONE;
                LVL_EL3: begin
                    bank_sel = ctx.nonsec ? BANK_NSEC : BANK_SEC;
                    if (ctx.write && !ctx.nonsec && (ctx.lock_a || ctx.lock_b))
                        verdict = OUT_UNDEF;
                end
            endcase
        end
    end
endmodule

// File: rtl/attr_bank_store.sv
module attr_bank_store
    import attr_reg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [BANK_SEL_W-1:0]         wr_sel,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [BANK_SEL_W-1:0]         rd_sel,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_BANKS*DATA_W-1:0]   banks_flat
);
    logic [DATA_W-1:0] bank_q [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (wr_en && (wr_sel == BANK_SEL_W'(g)))
                bank_q[g] <= wr_data;
        end
        assign banks_flat[g*DATA_W +: DATA_W] = bank_q[g];
    end

    assign rd_data = bank_q[rd_sel];
endmodule

// File: rtl/attr_reg_gate.sv
module attr_reg_gate
    import attr_reg_pkg::*;
#(
    parameter int         DATA_W    = 32,
    parameter int         SYND_W    = 8,
    parameter logic [7:0] SYND_CODE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_coproc,
    input  logic [2:0]        req_opc1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_opc2,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              feat_present,
    input  logic [1:0]        cur_level,
    input  logic              hyp_enable,
    input  logic              trap_crn10,
    input  logic              trap_vm_read,
    input  logic              trap_vm_write,
    input  logic              nonsecure,
    input  logic              sec_lock_a,
    input  logic              sec_lock_b,
    output logic              rsp_valid,
    output logic [1:0]        rsp_outcome,
    output logic [SYND_W-1:0] rsp_syndrome,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic                        hit;
    logic                        accept;
    state_e                      state_q, state_d;
    ctx_t                        ctx_q;
    logic [DATA_W-1:0]           wdata_q;
    outcome_e                    verdict;
    logic [BANK_SEL_W-1:0]       bank_sel;
    logic                        commit;
    logic [DATA_W-1:0]           bank_rd;
    logic [NUM_BANKS*DATA_W-1:0] banks_flat;

    attr_enc_match u_match (
        .coproc (req_coproc),
        .opc1   (req_opc1),
        .crn    (req_crn),
        .crm    (req_crm),
        .opc2   (req_opc2),
        .hit    (hit)
    );

    assign accept = req_valid && hit;

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctx_q <= '{write: req_write, lvl: level_e'(cur_level), feat: feat_present,
                           hyp_en: hyp_enable, trap_grp: trap_crn10, trap_vm_rd: trap_vm_read,
                           trap_vm_wr: trap_vm_write, nonsec: nonsecure,
                           lock_a: sec_lock_a, lock_b: sec_lock_b};
                wdata_q <= req_wdata;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = accept ? ST_RESP : ST_IDLE;
        endcase
    end

    attr_access_judge u_judge (
        .ctx      (ctx_q),
        .verdict  (verdict),
        .bank_sel (bank_sel)
    );

    assign commit = (state_q == ST_RESP) && (verdict == OUT_DONE) && ctx_q.write;

    attr_bank_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_sel     (bank_sel),
        .wr_data    (wdata_q),
        .rd_sel     (bank_sel),
        .rd_data    (bank_rd),
        .banks_flat (banks_flat)
    );

    // response outputs
    always_comb begin
        rsp_valid    = 1'b0;
        rsp_outcome  = OUT_DONE;
        rsp_syndrome = '0;
        rsp_rdata    = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_valid    = 1'b1;
                rsp_outcome  = verdict;
                rsp_syndrome = (verdict == OUT_TRAP) ? SYND_W'(SYND_CODE) : '0;
                rsp_rdata    = (verdict == OUT_DONE && !ctx_q.write) ? bank_rd : '0;
            end
        endcase
    end
endmodule

// File: rtl/attr_reg_gate_chk.sv
module attr_reg_gate_chk #(
    parameter int         DATA_W    = 32,
    parameter int         SYND_W    = 8,
    parameter logic [7:0] SYND_CODE = 8'h03,
    parameter int         FLAT_W    = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              hit,
    input logic              feat_present,
    input logic [1:0]        cur_level,
    input logic              nonsecure,
    input logic              sec_lock_a,
    input logic              sec_lock_b,
    input logic              rsp_valid,
    input logic [1:0]        rsp_outcome,
    input logic [SYND_W-1:0] rsp_syndrome,
    input logic              cap_write,
    input logic [FLAT_W-1:0] banks_flat
);
    assert_resp_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && hit));

    assert_nomatch_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && hit) |=> !rsp_valid);

    assert_feat_absent_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && !feat_present) |=> (rsp_valid && rsp_outcome == 2'd2));

    assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cur_level == 2'd0) |=> (rsp_valid && rsp_outcome == 2'd2));

    assert_trap_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == 2'd1) |-> (rsp_syndrome == SYND_W'(SYND_CODE)));

    assert_syndrome_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome != 2'd1) |-> (rsp_syndrome == '0));

    assert_outcome_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_outcome != 2'd3));

    assert_sec_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && feat_present && cur_level == 2'd3 && !nonsecure && req_write
         && (sec_lock_a || sec_lock_b)) |=> (rsp_outcome == 2'd2));

    assert_banks_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_outcome == 2'd0 && cap_write) |=> $stable(banks_flat));
endmodule

bind attr_reg_gate attr_reg_gate_chk #(
    .DATA_W    (DATA_W),
    .SYND_W    (SYND_W),
    .SYND_CODE (SYND_CODE),
    .FLAT_W    (NUM_BANKS * DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .hit          (hit),
    .feat_present (feat_present),
    .cur_level    (cur_level),
    .nonsecure    (nonsecure),
    .sec_lock_a   (sec_lock_a),
    .sec_lock_b   (sec_lock_b),
    .rsp_valid    (rsp_valid),
    .rsp_outcome  (rsp_outcome),
    .rsp_syndrome (rsp_syndrome),
    .cap_write    (ctx_q.write),
    .banks_flat   (banks_flat)
);

// File: tb/attr_reg_gate_bench.sv
module attr_reg_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_coproc = 4'd15, req_crn = 4'd10, req_crm = 4'd2;
    logic [2:0]  req_opc1 = 3'd0, req_opc2 = 3'd1;
    logic [31:0] req_wdata = '0;
    logic        feat_present = 1'b1, hyp_enable = 1'b0, trap_crn10 = 1'b0;
    logic        trap_vm_read = 1'b0, trap_vm_write = 1'b0, nonsecure = 1'b0;
    logic        sec_lock_a = 1'b0, sec_lock_b = 1'b0;
    logic [1:0]  cur_level = 2'd1;
    logic        rsp_valid;
    logic [1:0]  rsp_outcome;
    logic [7:0]  rsp_syndrome;
    logic [31:0] rsp_rdata;

    int   n_checks = 0;
    int   n_errors = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_reg_gate u_attr_reg_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_coproc(req_coproc), .req_opc1(req_opc1), .req_crn(req_crn),
        .req_crm(req_crm), .req_opc2(req_opc2), .req_wdata(req_wdata),
        .feat_present(feat_present), .cur_level(cur_level), .hyp_enable(hyp_enable),
        .trap_crn10(trap_crn10), .trap_vm_read(trap_vm_read),
        .trap_vm_write(trap_vm_write), .nonsecure(nonsecure),
        .sec_lock_a(sec_lock_a), .sec_lock_b(sec_lock_b),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome),
        .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata)
    );

    // {wr, level[1:0], feat, hyp, t10, tvm_wr, tvm_rd, ns, lock_a, lock_b, expected[1:0], pad[2:0]}
    function automatic logic [15:0] vec(logic wr, logic [1:0] el, logic ft, logic hy,
                                        logic t10, logic tw, logic tr, logic ns,
                                        logic la, logic lb, logic [1:0] ex);
        return {wr, el, ft, hy, t10, tw, tr, ns, la, lb, ex, 3'b000};
    endfunction

    localparam logic [15:0] VECS [N_VEC] = '{
        vec(0, 1, 0, 1, 1, 0, 0, 0, 0, 0, 2),  // R2 feature absent beats trap
        vec(1, 3, 0, 0, 0, 0, 0, 1, 0, 0, 2),  // R2 feature absent at EL3
        vec(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2),  // R3 EL0 read
        vec(1, 0, 1, 1, 1, 1, 1, 0, 0, 0, 2),  // R3 EL0 write
        vec(0, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1),  // R4 group trap on read
        vec(1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 1),  // R4 group trap on write
        vec(0, 1, 1, 1, 0, 0, 1, 0, 0, 0, 1),  // R5 read trap bit
        vec(0, 1, 1, 1, 0, 1, 0, 0, 0, 0, 0),  // R5 write bit ignored on read
        vec(1, 1, 1, 1, 0, 1, 0, 0, 0, 0, 1),  // R5 write trap bit
        vec(1, 1, 1, 1, 0, 0, 1, 0, 0, 0, 0),  // R5 read bit ignored on write
        vec(0, 1, 1, 0, 1, 1, 1, 0, 0, 0, 0),  // R5 hypervisor off, no trap
        vec(1, 2, 1, 1, 1, 1, 1, 0, 0, 0, 0),  // R6 no traps at EL2
        vec(1, 3, 1, 0, 0, 0, 0, 0, 1, 0, 2),  // R8 lock a blocks secure write
        vec(1, 3, 1, 0, 0, 0, 0, 0, 0, 1, 2),  // R8 lock b blocks secure write
        vec(0, 3, 1, 0, 0, 0, 0, 0, 1, 1, 0),  // R8 secure read not blocked
        vec(1, 3, 1, 0, 0, 0, 0, 1, 1, 1, 0),  // R8 nonsecure write not blocked
        vec(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0)   // R7 secure write done
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_ctx(logic [1:0] el, logic ft, logic hy, logic t10, logic tw,
                           logic tr, logic ns, logic la, logic lb);
        cur_level = el; feat_present = ft; hyp_enable = hy; trap_crn10 = t10;
        trap_vm_write = tw; trap_vm_read = tr; nonsecure = ns;
        sec_lock_a = la; sec_lock_b = lb;
    endtask

    // drive one request for one cycle; on return the response cycle is sampled
    task automatic fire(logic wr, logic [31:0] data);
        @(negedge clk);
        req_write = wr; req_wdata = data; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd_bank(logic [1:0] el, logic ns, logic [31:0] exp, string req);
        set_ctx(el, 1, 0, 0, 0, 0, ns, 0, 0);
        fire(0, '0);
        check(req, {31'd0, rsp_valid}, 32'd1);
        check(req, {30'd0, rsp_outcome}, 32'd0);
        check(req, rsp_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL R10: watchdog expired, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {31'd0, rsp_valid}, 32'd0);

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            logic [15:0] v;
            v = VECS[i];
            set_ctx(v[14:13], v[12], v[11], v[10], v[9], v[8], v[7], v[6], v[5]);
            fire(v[15], 32'h0);
            check($sformatf("R10 vec%0d valid", i), {31'd0, rsp_valid}, 32'd1);
            check($sformatf("R2-8 vec%0d outcome", i), {30'd0, rsp_outcome}, {30'd0, v[4:3]});
            check($sformatf("R4 vec%0d syndrome", i), {24'd0, rsp_syndrome},
                  (v[4:3] == 2'd1) ? 32'h03 : 32'h0);
            @(negedge clk);
            check($sformatf("R10 vec%0d pulse ends", i), {31'd0, rsp_valid}, 32'd0);
        end

        // fresh reset for directed tests
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_bank(3, 0, 32'h0, "R11 secure bank resets to zero");
        rd_bank(3, 1, 32'h0, "R11 nonsecure bank resets to zero");

        // R7 secure write then read both banks
        set_ctx(3, 1, 0, 0, 0, 0, 0, 0, 0);
        fire(1, 32'h1111_2222);
        check("R10 write rdata zero", rsp_rdata, 32'h0);
        rd_bank(3, 0, 32'h1111_2222, "R7 secure bank read");
        rd_bank(3, 1, 32'h0, "R7 nonsecure bank untouched");

        // R6 EL1 write lands in nonsecure bank
        set_ctx(1, 1, 0, 0, 0, 0, 0, 0, 0);
        fire(1, 32'h3333_4444);
        rd_bank(3, 1, 32'h3333_4444, "R6 EL1 write to nonsecure bank");
        rd_bank(2, 0, 32'h3333_4444, "R6 EL2 reads nonsecure bank");
        rd_bank(3, 0, 32'h1111_2222, "R6 secure bank unaffected");

        // R11 failed writes change nothing
        set_ctx(1, 1, 1, 1, 0, 0, 0, 0, 0);
        fire(1, 32'hDEAD_0001);
        check("R11 trapped write outcome", {30'd0, rsp_outcome}, 32'd1);
        set_ctx(3, 1, 0, 0, 0, 0, 0, 1, 0);
        fire(1, 32'hDEAD_0002);
        check("R11 locked write outcome", {30'd0, rsp_outcome}, 32'd2);
        rd_bank(1, 1, 32'h3333_4444, "R11 nonsecure kept after failed writes");
        rd_bank(3, 0, 32'h1111_2222, "R11 secure kept after failed writes");
        set_ctx(0, 1, 0, 0, 0, 0, 0, 0, 0);
        fire(0, '0);
        check("R10 undefined read rdata zero", rsp_rdata, 32'h0);

        // R1 non-matching encodings ignored
        set_ctx(3, 1, 0, 0, 0, 0, 1, 0, 0);
        req_crm = 4'd3;
        fire(1, 32'hBAD0_0003);
        check("R1 wrong CRm no response", {31'd0, rsp_valid}, 32'd0);
        req_crm = 4'd2; req_opc2 = 3'd0;
        fire(1, 32'hBAD0_0004);
        check("R1 wrong opc2 no response", {31'd0, rsp_valid}, 32'd0);
        req_opc2 = 3'd1; req_coproc = 4'd14;
        fire(1, 32'hBAD0_0005);
        check("R1 wrong coprocessor no response", {31'd0, rsp_valid}, 32'd0);
        req_coproc = 4'd15;
        rd_bank(3, 1, 32'h3333_4444, "R1 ignored writes left bank");

        // R10 back-to-back write then read
        set_ctx(3, 1, 0, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        req_write = 1'b1; req_wdata = 32'hAAAA_5555; req_valid = 1'b1;
        @(negedge clk);
        check("R10 first of pair valid", {31'd0, rsp_valid}, 32'd1);
        req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second of pair valid", {31'd0, rsp_valid}, 32'd1);
        check("R10 second of pair sees new data", rsp_rdata, 32'hAAAA_5555);
        @(negedge clk);
        check("R10 pair ends", {31'd0, rsp_valid}, 32'd0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule